// File: doc/BRIEF.md
# Gain-Ranging ADC Input Scaler

The block normalises samples from two converter channels, A and B, into one common fixed-point format for a decimating filter further down the chain. Each channel presents a signed mantissa, a small unsigned gain code and a strobe that marks a valid sample, all on one clock. The block turns the gain code into a right shift and applies it to the mantissa. This lets a converter with stepped gain feed the same filter as a plain fixed-point converter. With a plain fixed-point converter, the gain inputs are tied to zero and the narrower data is wired to the top mantissa bits.

One configuration word controls both channels. It holds an invert flag, a 3-bit offset and two 5-bit filter scale values: one for the loud input range and one for the quiet range. The shift is the gain code plus the offset, modulo 8. When the invert flag is set, the one's complement of the gain code is used in place of the code. This lets a gain code that rises with signal strength map onto a falling amount of attenuation. Each channel has its own range select that picks which scale value travels downstream with the sample. The output carries seven fractional bits, so even the largest shift loses no precision.

Top module: `gr_input_scaler`

## Requirements
- R1: While `rst_n` is low, every output is zero (both `*_valid` low, `*_data` zero, `*_scale` zero) and the configuration word resets to all zeros.
- R2: With the invert flag clear, the shift applied to a sample is (exponent + offset) mod 8.
- R3: With the invert flag set, the shift applied to a sample is (7 − exponent + offset) mod 8. For example, offset 6 with exponent 5 gives shift 0, and offset 6 with exponent 0 gives shift 5.
- R4: The output data is the two's-complement mantissa times 128, arithmetically shifted right by the shift, in 21 bits. The result is exact for every mantissa from −8192 to 8191 and every shift from 0 to 7.
- R5: The output of a sample presented with its enable high appears one clock later. `*_valid` is the enable delayed by one clock.
- R6: When a port's enable is low, that port's `*_data` and `*_scale` keep their previous values in the next cycle.
- R7: A range select of 0 passes the quiet scale value (configuration bits 9..5). A range select of 1 passes the loud scale value (configuration bits 4..0). The value is registered alongside the data.
- R8: A configuration write, presented with `cfg_we` high in a given cycle, governs samples presented from the next cycle on. A sample presented in the same cycle as the write still uses the previous word.
- R9: The two ports are independent. Each uses only its own mantissa, exponent, enable and select, and both share the one configuration word.
- R10: In the configuration word, bit 10 is the invert flag and bits 13..11 are the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock for both ports |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 14 | Configuration word: offset[13:11], invert[10], quiet scale[9:5], loud scale[4:0] |
| a_en | input | 1 | Port A sample enable |
| a_sel | input | 1 | Port A range select (1 loud, 0 quiet) |
| a_exp | input | 3 | Port A unsigned gain code |
| a_mant | input | 14 | Port A two's-complement mantissa |
| b_en | input | 1 | Port B sample enable |
| b_sel | input | 1 | Port B range select (1 loud, 0 quiet) |
| b_exp | input | 3 | Port B unsigned gain code |
| b_mant | input | 14 | Port B two's-complement mantissa |
| a_valid | output | 1 | Port A output valid |
| a_data | output | 21 | Port A scaled sample, 7 fractional bits |
| a_scale | output | 5 | Port A selected filter scale value |
| b_valid | output | 1 | Port B output valid |
| b_data | output | 21 | Port B scaled sample, 7 fractional bits |
| b_scale | output | 5 | Port B selected filter scale value |

## Verification
The bench sweeps every combination of exponent and offset with the invert flag in both states. This catches a wrapped sum that is not reduced modulo 8, or an inversion computed as a negation, because either gives the wrong shift at codes such as 0 or 7. It drives the extreme mantissas −8192 and 8191 at every shift; a logical shift or a missing sign extension then shows up as a large positive value in place of a negative one. It writes the configuration on the same cycle as an enabled sample, so a design that lets the new word act at once is caught on that sample. It also toggles enables and selects independently per port, which exposes outputs that fail to hold, valid strobes off by a cycle, and swapped scale fields or ports.

// File: rtl/gr_pkg.sv
// Package: gr_pkg
// Shared widths and the configuration word layout for the input scaler.
// Assumes a shift range of 0 .. 2**EXP_W-1 positions.
package gr_pkg;
    localparam int MANT_W  = 14;
    localparam int EXP_W   = 3;
    localparam int SCALE_W = 5;
    localparam int FRAC_W  = (1 << EXP_W) - 1;
    localparam int OUT_W   = MANT_W + FRAC_W;
    localparam int CFG_W   = 2 * SCALE_W + 1 + EXP_W;

    // Field order matters: the word is written as a flat vector.
    typedef struct packed {
        logic [EXP_W-1:0]   offset;
        logic               invert;
        logic [SCALE_W-1:0] quiet;
        logic [SCALE_W-1:0] loud;
    } cfg_t;
endpackage

// File: rtl/gr_cfg_reg.sv
// Module: gr_cfg_reg
// Holds the configuration word. A write becomes visible on the cycle after
// the strobe, so a sample presented alongside a write still sees the old word.
// Assumes one writer and a synchronous active-low reset.
module gr_cfg_reg
    import gr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output cfg_t             cfg_q
);
    // Capture the written word, clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (we) begin
            cfg_q <= cfg_t'(wdata);
        end
    end
endmodule

// File: rtl/gr_shift_calc.sv
// Module: gr_shift_calc
// Turns a gain code into a right-shift amount: the code, or its one's
// complement when inverted, plus the offset, wrapped to EXP_W bits.
// Assumes the shift range is a power of two so the wrap is a truncation.
module gr_shift_calc #(
    parameter int EW = gr_pkg::EXP_W
) (
    input  logic [EW-1:0] code,
    input  logic          invert,
    input  logic [EW-1:0] offset,
    output logic [EW-1:0] shamt
);
    logic [EW-1:0] code_eff;

    // Pick the code polarity, then add the offset modulo 2**EW.
    always_comb begin
        code_eff = invert ? ~code : code;
        shamt    = code_eff + offset;
    end
endmodule

// File: rtl/gr_lane.sv
// Module: gr_lane
// One input channel: aligns the mantissa above FRAC_W fractional bits,
// shifts it arithmetically right, and registers data, valid and the chosen
// scale value. Outputs hold while the enable is low.
// Assumes the configuration word is already registered by the caller.
module gr_lane
    import gr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  cfg_t              cfg,
    input  logic              en,
    input  logic              sel,
    input  logic [EXP_W-1:0]  expo,
    input  logic [MANT_W-1:0] mant,
    output logic              valid,
    output logic [OUT_W-1:0]  data,
    output logic [SCALE_W-1:0] scale
);
    logic [EXP_W-1:0]        shamt;
    logic signed [OUT_W-1:0] aligned;
    logic signed [OUT_W-1:0] shifted;
    logic [SCALE_W-1:0]      scale_sel;

    gr_shift_calc #(.EW(EXP_W)) u_shift (
        .code   (expo),
        .invert (cfg.invert),
        .offset (cfg.offset),
        .shamt  (shamt)
    );

    // Place the mantissa above the fraction and apply the signed shift.
    always_comb begin
        aligned   = signed'({mant, {FRAC_W{1'b0}}});
        shifted   = aligned >>> shamt;
        scale_sel = sel ? cfg.loud : cfg.quiet;
    end

    // Register the result on enabled samples; valid tracks the enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            data  <= '0;
            scale <= '0;
        end else begin
            valid <= en;
            if (en) begin
                data  <= shifted;
                scale <= scale_sel;
            end
        end
    end
endmodule

// File: rtl/gr_input_scaler.sv
// Module: gr_input_scaler
// Two-channel front-end normaliser for fixed-point or stepped-gain
// converters. One shared configuration word, one lane per channel.
// Assumes both channels run on the same clock as the configuration write.
module gr_input_scaler
    import gr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CFG_W-1:0]   cfg_wdata,
    input  logic               a_en,
    input  logic               a_sel,
    input  logic [EXP_W-1:0]   a_exp,
    input  logic [MANT_W-1:0]  a_mant,
    input  logic               b_en,
    input  logic               b_sel,
    input  logic [EXP_W-1:0]   b_exp,
    input  logic [MANT_W-1:0]  b_mant,
    output logic               a_valid,
    output logic [OUT_W-1:0]   a_data,
    output logic [SCALE_W-1:0] a_scale,
    output logic               b_valid,
    output logic [OUT_W-1:0]   b_data,
    output logic [SCALE_W-1:0] b_scale
);
    localparam int NLANE = 2;

    cfg_t               cfg_q;
    logic [NLANE-1:0]   en_v;
    logic [NLANE-1:0]   sel_v;
    logic [EXP_W-1:0]   exp_v   [NLANE];
    logic [MANT_W-1:0]  mant_v  [NLANE];
    logic [NLANE-1:0]   valid_v;
    logic [OUT_W-1:0]   data_v  [NLANE];
    logic [SCALE_W-1:0] scale_v [NLANE];

    gr_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg_q (cfg_q)
    );

    // Gather the named channel ports into lane arrays.
    always_comb begin
        en_v      = {b_en, a_en};
        sel_v     = {b_sel, a_sel};
        exp_v[0]  = a_exp;
        exp_v[1]  = b_exp;
        mant_v[0] = a_mant;
        mant_v[1] = b_mant;
    end

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        gr_lane u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .cfg   (cfg_q),
            .en    (en_v[i]),
            .sel   (sel_v[i]),
            .expo  (exp_v[i]),
            .mant  (mant_v[i]),
            .valid (valid_v[i]),
            .data  (data_v[i]),
            .scale (scale_v[i])
        );
    end

    // Spread the lane results back onto the named output ports.
    always_comb begin
        a_valid = valid_v[0];
        b_valid = valid_v[1];
        a_data  = data_v[0];
        b_data  = data_v[1];
        a_scale = scale_v[0];
        b_scale = scale_v[1];
    end
endmodule

// File: rtl/gr_scaler_chk.sv
// Module: gr_scaler_chk
// Temporal checks on the scaler ports and its registered configuration word.
// Bound into gr_input_scaler below.
module gr_scaler_chk
    import gr_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input cfg_t               cfg_q,
    input logic               a_en,
    input logic               a_sel,
    input logic [EXP_W-1:0]   a_exp,
    input logic [MANT_W-1:0]  a_mant,
    input logic               b_en,
    input logic               a_valid,
    input logic [OUT_W-1:0]   a_data,
    input logic [SCALE_W-1:0] a_scale,
    input logic               b_valid,
    input logic [OUT_W-1:0]   b_data,
    input logic [SCALE_W-1:0] b_scale
);
    // R5
    a_valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a_en |=> a_valid);
    // R5
    a_valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !a_en |=> !a_valid);
    // R9
    b_valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_en |=> b_valid);
    // R6
    a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !a_en |=> ($stable(a_data) && $stable(a_scale)));
    // R6
    b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !b_en |=> ($stable(b_data) && $stable(b_scale)));
    // R7
    a_loud_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && a_sel) |=> (a_scale == $past(cfg_q.loud)));
    // R7
    a_quiet_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && !a_sel) |=> (a_scale == $past(cfg_q.quiet)));
    // R2
    a_no_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && !cfg_q.invert && cfg_q.offset == '0 && a_exp == '0)
        |=> (a_data == $past({a_mant, {FRAC_W{1'b0}}})));
endmodule

bind gr_input_scaler gr_scaler_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_q   (cfg_q),
    .a_en    (a_en),
    .a_sel   (a_sel),
    .a_exp   (a_exp),
    .a_mant  (a_mant),
    .b_en    (b_en),
    .a_valid (a_valid),
    .a_data  (a_data),
    .a_scale (a_scale),
    .b_valid (b_valid),
    .b_data  (b_data),
    .b_scale (b_scale)
);

// File: tb/tb_gr_input_scaler.sv
module tb_gr_input_scaler;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [13:0] cfg_wdata = '0;
    logic        en   [2];
    logic        sel  [2];
    logic [2:0]  expo [2];
    logic [13:0] mant [2];
    logic        a_valid, b_valid;
    logic [20:0] a_data, b_data;
    logic [4:0]  a_scale, b_scale;

    int errors = 0;
    int checks = 0;
    string tag = "R1";
    bit done = 1'b0;

    // Behavioural model state.
    int          cfg_m = 0;
    bit          exp_valid [2];
    logic [20:0] exp_data  [2];
    logic [4:0]  exp_scale [2];
    int unsigned lcg = 32'h1234_5678;

    always #10 clk = ~clk;

    gr_input_scaler dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .a_en(en[0]), .a_sel(sel[0]), .a_exp(expo[0]), .a_mant(mant[0]),
        .b_en(en[1]), .b_sel(sel[1]), .b_exp(expo[1]), .b_mant(mant[1]),
        .a_valid(a_valid), .a_data(a_data), .a_scale(a_scale),
        .b_valid(b_valid), .b_data(b_data), .b_scale(b_scale)
    );

    function automatic int rnd();
        lcg = lcg * 32'd1103515245 + 32'd12345;
        return int'(lcg >> 8);
    endfunction

    function automatic logic [13:0] mkcfg(int inv, int off, int quiet, int loud);
        logic [13:0] w;
        w[13:11] = off[2:0];
        w[10]    = inv[0];
        w[9:5]   = quiet[4:0];
        w[4:0]   = loud[4:0];
        return w;
    endfunction

    function automatic logic [20:0] ref_data(logic [13:0] m, int e, int cfg);
        int     inv, off, sh;
        longint v;
        inv = (cfg >> 10) & 1;
        off = (cfg >> 11) & 7;
        sh  = inv ? ((7 - e + off) % 8) : ((e + off) % 8);
        v   = longint'($signed(m)) * 128;
        v   = v >>> sh;
        return v[20:0];
    endfunction

    task automatic chk(bit ok, string what, longint act, longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    task automatic compare();
        chk(a_valid == exp_valid[0], "a_valid", a_valid, exp_valid[0]);
        chk(a_data  == exp_data[0],  "a_data",  a_data,  exp_data[0]);
        chk(a_scale == exp_scale[0], "a_scale", a_scale, exp_scale[0]);
        chk(b_valid == exp_valid[1], "b_valid", b_valid, exp_valid[1]);
        chk(b_data  == exp_data[1],  "b_data",  b_data,  exp_data[1]);
        chk(b_scale == exp_scale[1], "b_scale", b_scale, exp_scale[1]);
    endtask

    // One clock: check last cycle's results, predict this cycle's, drive.
    task automatic step(bit we, logic [13:0] wd,
                        bit e0, bit s0, int x0, int m0,
                        bit e1, bit s1, int x1, int m1);
        bit          ne [2];
        bit          ns [2];
        int          nx [2];
        logic [13:0] nm [2];
        @(negedge clk);
        compare();
        ne[0] = e0; ns[0] = s0; nx[0] = x0 & 7; nm[0] = m0[13:0];
        ne[1] = e1; ns[1] = s1; nx[1] = x1 & 7; nm[1] = m1[13:0];
        for (int p = 0; p < 2; p++) begin
            if (rst_n) begin
                exp_valid[p] = ne[p];
                if (ne[p]) begin
                    exp_data[p]  = ref_data(nm[p], nx[p], cfg_m);
                    exp_scale[p] = ns[p] ? cfg_m[4:0] : cfg_m[9:5];
                end
            end
            en[p] = ne[p]; sel[p] = ns[p]; expo[p] = nx[p][2:0]; mant[p] = nm[p];
        end
        cfg_we    = we;
        cfg_wdata = wd;
        if (we && rst_n) cfg_m = int'(wd);
    endtask

    task automatic wr(logic [13:0] wd);
        step(1'b1, wd, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog timeout actual=0 expected=1");
        finish_run();
    end

    initial begin
        for (int p = 0; p < 2; p++) begin
            en[p] = 0; sel[p] = 0; expo[p] = 0; mant[p] = 0;
            exp_valid[p] = 0; exp_data[p] = 0; exp_scale[p] = 0;
        end
        // R1: reset state, with stimulus that must not leak through.
        tag = "R1";
        step(1, 14'h3FFF, 1, 1, 5, 1234, 1, 0, 3, -77);
        step(0, 0, 1, 1, 2, 999, 1, 1, 1, 55);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

        // R2: invert clear, every offset and exponent.
        tag = "R2";
        for (int off = 0; off < 8; off++) begin
            wr(mkcfg(0, off, 9, 22));
            for (int e = 0; e < 8; e++)
                step(0, 0, 1, 0, e, 3001 - 701 * e, 1, 1, 7 - e, -4093 + 311 * e);
        end

        // R3: invert set, every offset and exponent (includes offset 6 cases).
        tag = "R3";
        for (int off = 0; off < 8; off++) begin
            wr(mkcfg(1, off, 17, 3));
            for (int e = 0; e < 8; e++)
                step(0, 0, 1, 1, e, -5000 + 977 * e, 1, 0, e, 6123 - 1009 * e);
        end

        // R4: extreme mantissas at every shift.
        tag = "R4";
        wr(mkcfg(0, 0, 1, 2));
        for (int s = 0; s < 8; s++) begin
            step(0, 0, 1, 0, s, -8192, 1, 0, s, 8191);
            step(0, 0, 1, 1, s, -1, 1, 1, s, 1);
        end

        // R5 and R6: irregular enables per port, outputs must hold when idle.
        tag = "R5";
        wr(mkcfg(1, 6, 12, 25));
        for (int i = 0; i < 40; i++) begin
            if (i == 20) tag = "R6";
            step(0, 0, rnd() % 3 == 0, rnd() % 2, rnd(), rnd(),
                       rnd() % 2 == 0, rnd() % 2, rnd(), rnd());
        end

        // R7: range select picks quiet or loud field.
        tag = "R7";
        wr(mkcfg(0, 0, 5'h15, 5'h0A));
        for (int i = 0; i < 8; i++)
            step(0, 0, 1, i[0], i, 100 * i, 1, ~i[0], i, -100 * i);

        // R8: writes on the same cycle as enabled samples.
        tag = "R8";
        for (int i = 0; i < 30; i++)
            step(1, 14'(rnd()), 1, rnd() % 2, rnd(), rnd(), 1, rnd() % 2, rnd(), rnd());

        // R10: specific field positions of invert and offset.
        tag = "R10";
        wr(mkcfg(1, 3, 0, 31));
        step(0, 0, 1, 1, 2, 4000, 1, 0, 6, -4000);
        wr(mkcfg(0, 5, 31, 0));
        step(0, 0, 1, 1, 2, 4000, 1, 0, 6, -4000);

        // R9: ports driven independently with mixed everything.
        tag = "R9";
        wr(mkcfg(1, 2, 7, 19));
        for (int i = 0; i < 30; i++)
            step(i % 5 == 0, 14'(rnd()), i % 2 == 0, rnd() % 2, rnd(), rnd(),
                 i % 3 != 0, rnd() % 2, rnd(), rnd());

        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        compare();
        finish_run();
    end
endmodule